// File: doc/BRIEF.md
# Load-use hazard stall unit

This block lives in the decode stage of an in-order five-stage pipeline. It detects the case where the instruction in decode needs a register that a load, one slot ahead in execute, has not yet brought back from memory. On that hazard it holds the fetch address and the fetch/decode pipeline register for one cycle. It also replaces the decoded control bundle heading into execute with all zeros, so the stalled slot travels down the pipeline as a no-op.

The block compares the execute-stage load's destination register against both decode-stage source registers. It stalls only when the instruction in execute actually reads memory. Every other dependency is left to the forwarding network, which is not part of this block. A load followed at once by a dependent instruction therefore costs exactly one bubble. After that bubble the load has moved on and forwarding can supply its data. The execute-stage control register is part of the block: it takes the muxed bundle on each clock and clears to zero on reset.

Top module: `ldu_stall_unit`

## Requirements
- R1: When `ex_load_i` is 1 and `ex_dst_i` equals `dec_rs_i`, in the same cycle `pc_wr_en_o` and `ifid_wr_en_o` are 0 and `bubble_o` is 1.
- R2: When `ex_load_i` is 1 and `ex_dst_i` equals `dec_rt_i`, in the same cycle `pc_wr_en_o` and `ifid_wr_en_o` are 0 and `bubble_o` is 1.
- R3: When `ex_load_i` is 0, `pc_wr_en_o` and `ifid_wr_en_o` are 1 and `bubble_o` is 0, even if `ex_dst_i` matches a source register.
- R4: When `ex_load_i` is 1 but `ex_dst_i` matches neither source register, there is no stall: both enables are 1 and `bubble_o` is 0.
- R5: After a clock edge at which `bubble_o` was 1, `ex_ctrl_o` is all zeros, whatever `dec_ctrl_i` was.
- R6: After a clock edge at which `bubble_o` was 0, `ex_ctrl_o` equals the `dec_ctrl_i` value present at that edge.
- R7: While `rst_n` is 0 at a clock edge, `ex_ctrl_o` becomes all zeros.
- R8: In every cycle `pc_wr_en_o` equals `ifid_wr_en_o`, and both are the inverse of `bubble_o`.
- R9: In a pipeline where a load is followed at once by a dependent instruction, exactly one stall cycle occurs. A dependent instruction two slots behind the load causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_rs_i | input | REG_AW | First source register number of the instruction in decode |
| dec_rt_i | input | REG_AW | Second source register number of the instruction in decode |
| dec_ctrl_i | input | CTRL_W | Decoded control bundle for execute, memory and writeback |
| ex_load_i | input | 1 | The instruction in execute reads memory |
| ex_dst_i | input | REG_AW | Destination register of the instruction in execute |
| pc_wr_en_o | output | 1 | Program counter update enable |
| ifid_wr_en_o | output | 1 | Fetch/decode pipeline register write enable |
| bubble_o | output | 1 | Bubble select: zeroes the bundle passed to execute |
| ex_ctrl_o | output | CTRL_W | Registered control bundle now in execute |

## Verification
The checker tests on every cycle several properties. It checks that a load match on either source register forces a stall. It checks that no load means no stall. It checks that the two enables agree with each other and with the bubble select. It checks that the registered bundle is zero after a bubble and a copy of the decoded bundle otherwise. Some behaviours span several cycles of a real instruction stream, and only the bench's directed scenarios can show them. These are the one-bubble cost of a load-use pair, the absence of a stall for an independent instruction or one two slots behind the load, and the reset value of the execute control register.

// File: rtl/ldu_pkg.sv
package ldu_pkg;

   // number of source operands compared per decoded instruction
   localparam int unsigned LDU_NUM_SRC = 2;

   // bubble mux implementation variants
   localparam int unsigned LDU_MUX_TERNARY = 0;
   localparam int unsigned LDU_MUX_ANDMASK = 1;

   // OR-reduce a vector of per-source hit flags
   function automatic logic ldu_any(input logic [LDU_NUM_SRC-1:0] hits);
      return |hits;
   endfunction

endpackage

// File: rtl/ldu_src_match.sv
module ldu_src_match #(
   parameter int unsigned REG_AW = 5
) (
   input  logic [REG_AW-1:0] src_i,
   input  logic [REG_AW-1:0] dst_i,
   input  logic              load_i,
   output logic              hit_o
);

   if (REG_AW < 1) begin : g_bad_aw
      $error("ldu_src_match: REG_AW must be at least 1");
   end

   logic same_reg;

   always_comb begin
      same_reg = (src_i == dst_i);
      hit_o    = load_i & same_reg;
   end

endmodule

// File: rtl/ldu_bubble_mux.sv
module ldu_bubble_mux #(
   parameter int unsigned CTRL_W    = 9,
   parameter int unsigned MUX_STYLE = 0
) (
   input  logic [CTRL_W-1:0] ctrl_i,
   input  logic              kill_i,
   output logic [CTRL_W-1:0] ctrl_o
);

   import ldu_pkg::*;

   if (CTRL_W < 1) begin : g_bad_w
      $error("ldu_bubble_mux: CTRL_W must be at least 1");
   end

   if (MUX_STYLE == LDU_MUX_ANDMASK) begin : g_andmask
      logic [CTRL_W-1:0] keep_mask;
      always_comb begin
         keep_mask = {CTRL_W{~kill_i}};
         ctrl_o    = ctrl_i & keep_mask;
      end
   end else if (MUX_STYLE == LDU_MUX_TERNARY) begin : g_ternary
      always_comb begin
         ctrl_o = kill_i ? '0 : ctrl_i;
      end
   end else begin : g_bad_style
      $error("ldu_bubble_mux: unknown MUX_STYLE");
      assign ctrl_o = '0;
   end

endmodule

// File: rtl/ldu_ctrl_stage.sv
module ldu_ctrl_stage #(
   parameter int unsigned CTRL_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] d_i,
   output logic [CTRL_W-1:0] q_o
);

   logic [CTRL_W-1:0] q_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_r <= '0;
      end else begin
         q_r <= d_i;
      end
   end

   assign q_o = q_r;

endmodule

// File: rtl/ldu_stall_unit.sv
module ldu_stall_unit #(
   parameter int unsigned REG_AW    = 5,
   parameter int unsigned CTRL_W    = 9,
   parameter int unsigned MUX_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] dec_rs_i,
   input  logic [REG_AW-1:0] dec_rt_i,
   input  logic [CTRL_W-1:0] dec_ctrl_i,
   input  logic              ex_load_i,
   input  logic [REG_AW-1:0] ex_dst_i,
   output logic              pc_wr_en_o,
   output logic              ifid_wr_en_o,
   output logic              bubble_o,
   output logic [CTRL_W-1:0] ex_ctrl_o
);

   import ldu_pkg::*;

   localparam int unsigned NSRC = LDU_NUM_SRC;

   if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
      $error("ldu_stall_unit: REG_AW out of range 1..8");
   end
   if (CTRL_W < 1) begin : g_bad_cw
      $error("ldu_stall_unit: CTRL_W must be at least 1");
   end

   logic [REG_AW-1:0] src_vec [NSRC];
   logic [NSRC-1:0]   src_hit;
   logic              stall;
   logic [CTRL_W-1:0] ctrl_muxed;

   assign src_vec[0] = dec_rs_i;
   assign src_vec[1] = dec_rt_i;

   for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
      ldu_src_match #(.REG_AW(REG_AW)) u_match (
         .src_i  (src_vec[gi]),
         .dst_i  (ex_dst_i),
         .load_i (ex_load_i),
         .hit_o  (src_hit[gi])
      );
   end

   assign stall = ldu_any(src_hit);

   ldu_bubble_mux #(.CTRL_W(CTRL_W), .MUX_STYLE(MUX_STYLE)) u_mux (
      .ctrl_i (dec_ctrl_i),
      .kill_i (stall),
      .ctrl_o (ctrl_muxed)
   );

   ldu_ctrl_stage #(.CTRL_W(CTRL_W)) u_exreg (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ctrl_muxed),
      .q_o   (ex_ctrl_o)
   );

   assign pc_wr_en_o   = ~stall;
   assign ifid_wr_en_o = ~stall;
   assign bubble_o     = stall;

endmodule

// File: rtl/ldu_stall_unit_chk.sv
module ldu_stall_unit_chk #(
   parameter int unsigned REG_AW = 5,
   parameter int unsigned CTRL_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic [REG_AW-1:0] dec_rs_i,
   input logic [REG_AW-1:0] dec_rt_i,
   input logic [CTRL_W-1:0] dec_ctrl_i,
   input logic              ex_load_i,
   input logic [REG_AW-1:0] ex_dst_i,
   input logic              pc_wr_en_o,
   input logic              ifid_wr_en_o,
   input logic              bubble_o,
   input logic [CTRL_W-1:0] ex_ctrl_o
);

   p_rs_match_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_load_i && ex_dst_i == dec_rs_i) |-> (!pc_wr_en_o && !ifid_wr_en_o && bubble_o));

   p_rt_match_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_load_i && ex_dst_i == dec_rt_i) |-> (!pc_wr_en_o && !ifid_wr_en_o && bubble_o));

   p_no_load_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_load_i |-> (pc_wr_en_o && ifid_wr_en_o && !bubble_o));

   p_no_match_no_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_dst_i != dec_rs_i && ex_dst_i != dec_rt_i) |-> !bubble_o);

   p_bubble_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_o |=> (ex_ctrl_o == '0));

   p_pass_through_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bubble_o |=> (ex_ctrl_o == $past(dec_ctrl_i)));

   p_enables_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_wr_en_o == ifid_wr_en_o) && (pc_wr_en_o != bubble_o));

endmodule

bind ldu_stall_unit ldu_stall_unit_chk #(.REG_AW(REG_AW), .CTRL_W(CTRL_W)) u_chk (.*);

// File: tb/sim_ldu_stall_unit.sv
module sim_ldu_stall_unit;

   localparam int unsigned AW = 5;
   localparam int unsigned CW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] dec_rs = '0;
   logic [AW-1:0] dec_rt = '0;
   logic [CW-1:0] dec_ctrl = '0;
   logic          ex_load = 1'b0;
   logic [AW-1:0] ex_dst = '0;
   logic          pc_wr_en, ifid_wr_en, bubble;
   logic [CW-1:0] ex_ctrl;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   ldu_stall_unit #(.REG_AW(AW), .CTRL_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .dec_rs_i(dec_rs), .dec_rt_i(dec_rt), .dec_ctrl_i(dec_ctrl),
      .ex_load_i(ex_load), .ex_dst_i(ex_dst),
      .pc_wr_en_o(pc_wr_en), .ifid_wr_en_o(ifid_wr_en),
      .bubble_o(bubble), .ex_ctrl_o(ex_ctrl)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive one cycle of inputs just after a falling edge and let them settle
   task automatic drive(input logic [AW-1:0] rs, input logic [AW-1:0] rt,
                        input logic [CW-1:0] ctl, input logic ld, input logic [AW-1:0] dst);
      @(negedge clk);
      dec_rs = rs; dec_rt = rt; dec_ctrl = ctl; ex_load = ld; ex_dst = dst;
      #1;
   endtask

   // check enables: stall expected or not
   task automatic chk_stall(input bit exp_stall, input string tag);
      chk(pc_wr_en == !exp_stall, {tag, " pc_wr_en"}, pc_wr_en, !exp_stall);
      chk(ifid_wr_en == !exp_stall, {tag, " ifid_wr_en"}, ifid_wr_en, !exp_stall);
      chk(bubble == exp_stall, {tag, " bubble"}, bubble, exp_stall);
   endtask

   // value of the execute bundle after the next rising edge
   task automatic chk_next_ctrl(input logic [CW-1:0] exp, input string tag);
      @(negedge clk); #1;
      chk(ex_ctrl == exp, tag, ex_ctrl, exp);
   endtask

   task automatic t_reset();
      dec_ctrl = 9'h1FF;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(ex_ctrl == '0, "R7 reset clears execute bundle", ex_ctrl, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_load_use_rs();
      drive(5'd7, 5'd3, 9'h155, 1'b1, 5'd7);
      chk_stall(1'b1, "R1 rs match");
      chk_next_ctrl('0, "R5 bubble after rs match");
   endtask

   task automatic t_load_use_rt();
      drive(5'd4, 5'd12, 9'h0AA, 1'b1, 5'd12);
      chk_stall(1'b1, "R2 rt match");
      chk_next_ctrl('0, "R5 bubble after rt match");
   endtask

   task automatic t_no_load_same_reg();
      drive(5'd9, 5'd9, 9'h123, 1'b0, 5'd9);
      chk_stall(1'b0, "R3 non-load same reg");
      chk_next_ctrl(9'h123, "R3 bundle passes without load");
   endtask

   task automatic t_load_independent();
      drive(5'd1, 5'd2, 9'h1A5, 1'b1, 5'd30);
      chk_stall(1'b0, "R4 independent after load");
      chk_next_ctrl(9'h1A5, "R6 pass-through");
   endtask

   // pipeline scenario: load r8 then a user of r8 directly behind it
   task automatic t_one_bubble();
      int stalls = 0;
      // load in execute, dependent in decode
      drive(5'd8, 5'd0, 9'h0F3, 1'b1, 5'd8);
      if (bubble) stalls++;
      // next cycle: execute holds the bubble (mem-read zero), decode held
      drive(5'd8, 5'd0, 9'h0F3, 1'b0, 5'd0);
      if (bubble) stalls++;
      chk_next_ctrl(9'h0F3, "R9 held instruction issues after bubble");
      chk(stalls == 1, "R9 load-use stall count", stalls, 1);
   endtask

   // load r6, one unrelated instruction, then a user of r6
   task automatic t_two_slot_gap();
      int stalls = 0;
      drive(5'd10, 5'd11, 9'h011, 1'b1, 5'd6);
      if (bubble) stalls++;
      drive(5'd6, 5'd6, 9'h022, 1'b0, 5'd13);
      if (bubble) stalls++;
      chk(stalls == 0, "R9 two-slot gap no stall", stalls, 0);
   endtask

   task automatic t_enable_agree();
      for (int k = 0; k < 8; k++) begin
         drive(AW'(k), AW'(k + 3), CW'(k * 37), k[0], AW'(k + 3 * k[1]));
         chk((pc_wr_en == ifid_wr_en) && (pc_wr_en != bubble),
             "R8 enables agree", {pc_wr_en, ifid_wr_en, bubble}, 0);
      end
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_load_use_rs();
      t_load_use_rt();
      t_no_load_same_reg();
      t_load_independent();
      t_one_bubble();
      t_two_slot_gap();
      t_enable_agree();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule